// File: doc/BRIEF.md
# Serial-Priority Vectored Interrupt Acknowledge Chain

This block collects interrupt requests from a row of module slots and answers them one at a time. Every slot holds a pending flag. The pending flags are ORed onto one shared request line. A small controller watches that line. When the line is high and no acknowledge is already travelling, the controller sends one acknowledge into slot 0. The acknowledge then moves down the row by one slot per clock.

The first slot that holds the acknowledge while its flag is set keeps the acknowledge and stops it. That slot puts a vector word on the shared data output for one cycle, with a valid strobe. The vector is either the slot's module address or its handler address, selected per slot. The same edge drops the slot's pending flag. When two requests are waiting at once, the slot nearer to slot 0 always wins. A slot's position is its only priority.

Top module: `daisy_vec_irq`

## Requirements
- R1: A one-cycle pulse on `reqSet[k]` sets the pending flag of slot k. From the next cycle `intReq` is high, and it stays high while any flag remains set.
- R2: The controller issues an acknowledge only while `intReq` is high and no acknowledge is in flight. The acknowledge sits at slot 0 in the following cycle.
- R3: The acknowledge moves one slot per clock past slots that are not pending. At most one slot holds it at any time.
- R4: The lowest-index pending slot absorbs the acknowledge. `vecValid` is high for exactly one cycle: the cycle in which the acknowledge sits at that slot. With all flags clear before, a pulse that sets slot k as the lowest pending slot gives `vecValid` two plus k cycles after the pulse cycle.
- R5: In the vector cycle of slot k, `vecData` equals `hndAddr[k*VEC_W +: VEC_W]` when `useHandler[k]` is 1. Otherwise it equals `modAddr[k*VEC_W +: VEC_W]`.
- R6: The responding slot's flag clears at the end of its vector cycle. A `reqSet` pulse to that slot in the same cycle wins, and the flag stays set.
- R7: A vector appears at most NUM_SLOTS cycles after the acknowledge is issued.
- R8: After a vector cycle the controller samples `intReq` again in the next cycle. The next vector, from slot j, therefore comes two plus j cycles after the previous vector cycle.
- R9: `vecData` is all zeros in every cycle in which `vecValid` is low.
- R10: A request set on a slot that the travelling acknowledge has already passed is not served by that acknowledge. It waits for the next round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqSet | input | NUM_SLOTS | Per-slot request pulse; bit k sets the pending flag of slot k |
| useHandler | input | NUM_SLOTS | Per-slot vector select: 1 = handler address, 0 = module address |
| modAddr | input | NUM_SLOTS*VEC_W | Packed module addresses; slot k at bits k*VEC_W +: VEC_W |
| hndAddr | input | NUM_SLOTS*VEC_W | Packed handler addresses; slot k at bits k*VEC_W +: VEC_W |
| intReq | output | 1 | Shared request line, the OR of all pending flags |
| vecValid | output | 1 | High during the single vector cycle |
| vecData | output | VEC_W | Vector word of the responding slot, zero otherwise |

## Verification
Two functions can fall in the same cycle at one slot. The first is the absorbing slot dropping its pending flag. The second is a new request arriving for that same slot. The bench provokes this by pulsing `reqSet` for slot 0 in slot 0's vector cycle, and judges the result by a second vector from slot 0 two cycles later. A related overlap is a request arriving behind an acknowledge that is still travelling. This request must be served only after the farther slot's vector. The bench checks this from the cycle offsets of both vectors. A sweep over every request pattern and every vector-select pattern of a four-slot chain checks the offset, the data and `intReq` in every cycle.

// File: rtl/dcv_pkg.sv
package dcv_pkg;
  // controller -> datapath
  typedef struct packed {
    logic ackIssue;
  } ctlStrb_t;
  // datapath -> controller
  typedef struct packed {
    logic hit;   // some slot absorbed the acknowledge this cycle
    logic lost;  // acknowledge left the last slot unanswered
  } dpStat_t;
endpackage

// File: rtl/dcv_slot.sv
module dcv_slot #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqSet,
  input  logic             ackPrev,
  input  logic             useHnd,
  input  logic [VEC_W-1:0] modAddr,
  input  logic [VEC_W-1:0] hndAddr,
  output logic             pending,
  output logic             ackHere,
  output logic             passOut,
  output logic             hit,
  output logic [VEC_W-1:0] vecOut
);
  assign hit     = ackHere & pending;
  assign passOut = ackHere & ~pending;
  assign vecOut  = hit ? (useHnd ? hndAddr : modAddr) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      ackHere <= 1'b0;
    end else begin
      pending <= reqSet | (pending & ~hit);
      ackHere <= ackPrev;
    end
  end
endmodule

// File: rtl/dcv_chain.sv
module dcv_chain
  import dcv_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int VEC_W     = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctlStrb_t                   strb,
  input  logic [NUM_SLOTS-1:0]       reqSet,
  input  logic [NUM_SLOTS-1:0]       useHandler,
  input  logic [NUM_SLOTS*VEC_W-1:0] modAddr,
  input  logic [NUM_SLOTS*VEC_W-1:0] hndAddr,
  output dpStat_t                    stat,
  output logic [NUM_SLOTS-1:0]       pendingVec,
  output logic [NUM_SLOTS-1:0]       ackVec,
  output logic                       intReq,
  output logic [VEC_W-1:0]           vecData
);
  logic [NUM_SLOTS:0]   passLink;
  logic [NUM_SLOTS-1:0] hitVec;
  logic [VEC_W-1:0]     slotVec [NUM_SLOTS];

  assign passLink[0] = strb.ackIssue;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    dcv_slot #(.VEC_W(VEC_W)) u_slot (
      .clk     (clk),
      .rstN    (rstN),
      .reqSet  (reqSet[i]),
      .ackPrev (passLink[i]),
      .useHnd  (useHandler[i]),
      .modAddr (modAddr[i*VEC_W +: VEC_W]),
      .hndAddr (hndAddr[i*VEC_W +: VEC_W]),
      .pending (pendingVec[i]),
      .ackHere (ackVec[i]),
      .passOut (passLink[i+1]),
      .hit     (hitVec[i]),
      .vecOut  (slotVec[i])
    );
  end

  always_comb begin
    vecData = '0;
    for (int i = 0; i < NUM_SLOTS; i++) vecData = vecData | slotVec[i];
  end

  assign intReq    = |pendingVec;
  assign stat.hit  = |hitVec;
  assign stat.lost = passLink[NUM_SLOTS];
endmodule

// File: rtl/dcv_ctrl.sv
module dcv_ctrl
  import dcv_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     intReq,
  input  dpStat_t  stat,
  output ctlStrb_t strb
);
  logic busy;

  assign strb.ackIssue = ~busy & intReq;

  always_ff @(posedge clk) begin
    if (!rstN)                     busy <= 1'b0;
    else if (strb.ackIssue)        busy <= 1'b1;
    else if (stat.hit | stat.lost) busy <= 1'b0;
  end
endmodule

// File: rtl/daisy_vec_irq.sv
module daisy_vec_irq
  import dcv_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int VEC_W     = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_SLOTS-1:0]       reqSet,
  input  logic [NUM_SLOTS-1:0]       useHandler,
  input  logic [NUM_SLOTS*VEC_W-1:0] modAddr,
  input  logic [NUM_SLOTS*VEC_W-1:0] hndAddr,
  output logic                       intReq,
  output logic                       vecValid,
  output logic [VEC_W-1:0]           vecData
);
  ctlStrb_t             strb;
  dpStat_t              stat;
  logic [NUM_SLOTS-1:0] pendingVec;
  logic [NUM_SLOTS-1:0] ackVec;

  dcv_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .intReq (intReq),
    .stat   (stat),
    .strb   (strb)
  );

  dcv_chain #(.NUM_SLOTS(NUM_SLOTS), .VEC_W(VEC_W)) u_chain (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .reqSet     (reqSet),
    .useHandler (useHandler),
    .modAddr    (modAddr),
    .hndAddr    (hndAddr),
    .stat       (stat),
    .pendingVec (pendingVec),
    .ackVec     (ackVec),
    .intReq     (intReq),
    .vecData    (vecData)
  );

  assign vecValid = stat.hit;
endmodule

// File: rtl/dcv_checker.sv
module dcv_checker #(
  parameter int NUM_SLOTS = 4,
  parameter int VEC_W     = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_SLOTS-1:0] reqSet,
  input logic                 intReq,
  input logic                 vecValid,
  input logic [VEC_W-1:0]     vecData,
  input logic                 ackIssue,
  input logic [NUM_SLOTS-1:0] ackVec,
  input logic [NUM_SLOTS-1:0] pendingVec
);
  localparam int CNT_W = $clog2(NUM_SLOTS + 2) + 1;

  logic             inFlight;
  logic [CNT_W-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFlight <= 1'b0;
      waitCnt  <= '0;
    end else if (ackIssue) begin
      inFlight <= 1'b1;
      waitCnt  <= '0;
    end else if (vecValid) begin
      inFlight <= 1'b0;
    end else if (inFlight && waitCnt <= CNT_W'(NUM_SLOTS)) begin
      waitCnt <= waitCnt + 1'b1;
    end
  end

  a_r2_issue_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    ackIssue |-> intReq);

  a_r3_ack_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ackVec));

  a_r4_single_vector: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |=> !vecValid);

  a_r6_withdraw: assert property (@(posedge clk) disable iff (!rstN)
    (vecValid && reqSet == '0) |=>
      $countones(pendingVec) == $countones($past(pendingVec)) - 1);

  a_r7_latency: assert property (@(posedge clk) disable iff (!rstN)
    inFlight |-> waitCnt < CNT_W'(NUM_SLOTS));

  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    ackIssue |=> !ackIssue);

  a_r9_bus_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !vecValid |-> vecData == '0);
endmodule

bind daisy_vec_irq dcv_checker #(.NUM_SLOTS(NUM_SLOTS), .VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqSet     (reqSet),
  .intReq     (intReq),
  .vecValid   (vecValid),
  .vecData    (vecData),
  .ackIssue   (strb.ackIssue),
  .ackVec     (ackVec),
  .pendingVec (pendingVec)
);

// File: tb/daisy_vec_irq_tb.sv
`timescale 1ns/1ps
module daisy_vec_irq_tb;
  localparam int N = 4;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [N-1:0]   reqSet = '0;
  logic [N-1:0]   useHandler = '0;
  logic [N*W-1:0] modAddr;
  logic [N*W-1:0] hndAddr;
  logic           intReq;
  logic           vecValid;
  logic [W-1:0]   vecData;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  daisy_vec_irq #(.NUM_SLOTS(N), .VEC_W(W)) u_dut (
    .clk(clk), .rstN(rstN), .reqSet(reqSet), .useHandler(useHandler),
    .modAddr(modAddr), .hndAddr(hndAddr),
    .intReq(intReq), .vecValid(vecValid), .vecData(vecData)
  );

  function automatic logic [W-1:0] expVec(int k, logic [N-1:0] sel);
    return sel[k] ? W'(8'hC0 + k*5) : W'(8'h10 + k);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Pulse a pattern, then judge every cycle offset against computed hit times.
  task automatic runPattern(logic [N-1:0] pat, logic [N-1:0] sel);
    int hitOff [N];
    int base = 0;
    for (int k = 0; k < N; k++) begin
      hitOff[k] = -1;
      if (pat[k]) begin
        hitOff[k] = base + 2 + k;   // R4 first, R8 subsequent
        base = hitOff[k];
      end
    end
    @(negedge clk);
    useHandler = sel;
    reqSet = pat;
    for (int off = 1; off <= 16; off++) begin
      @(negedge clk);
      reqSet = '0;
      begin
        bit eV = 0; bit eR = 0; logic [W-1:0] eD = '0;
        for (int k = 0; k < N; k++) begin
          if (hitOff[k] == off) begin eV = 1; eD = expVec(k, sel); end
          if (hitOff[k] >= off) eR = 1;
        end
        chk(vecValid == eV, "R4 vecValid", vecValid, eV);
        chk(vecData == eD, eV ? "R5 vecData" : "R9 vecData", vecData, eD);
        chk(intReq == eR, "R1 intReq", intReq, eR);
      end
    end
  endtask

  initial begin
    for (int k = 0; k < N; k++) begin
      modAddr[k*W +: W] = W'(8'h10 + k);
      hndAddr[k*W +: W] = W'(8'hC0 + k*5);
    end
    repeat (3) @(negedge clk);
    chk(intReq == 0, "R1 reset intReq", intReq, 0);
    chk(vecValid == 0, "R4 reset vecValid", vecValid, 0);
    chk(vecData == 0, "R9 reset vecData", vecData, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R7 R8 R9: sweep all request and select patterns
    for (int p = 0; p < (1 << N); p++)
      for (int s = 0; s < (1 << N); s++)
        runPattern(N'(p), N'(s));

    // R6: re-request of slot 0 in its own vector cycle wins over the clear
    @(negedge clk);
    useHandler = '0;
    reqSet = 4'b0001;
    @(negedge clk); reqSet = '0;               // offset 1
    @(negedge clk);                            // offset 2: vector cycle
    chk(vecValid == 1, "R6 first vector", vecValid, 1);
    reqSet = 4'b0001;
    @(negedge clk); reqSet = '0;               // offset 3
    chk(intReq == 1, "R6 flag kept", intReq, 1);
    chk(vecValid == 0, "R6 gap", vecValid, 0);
    @(negedge clk);                            // offset 4
    chk(vecValid == 1, "R6 second vector", vecValid, 1);
    chk(vecData == 8'h10, "R6 second data", vecData, 8'h10);
    @(negedge clk);
    chk(intReq == 0, "R6 drained", intReq, 0);

    // R10: slot 0 requests after the acknowledge has passed it
    repeat (2) @(negedge clk);
    reqSet = 4'b0100;
    @(negedge clk); reqSet = '0;               // offset 1: issue
    @(negedge clk);                            // offset 2: ack at slot 0
    reqSet = 4'b0001;
    @(negedge clk); reqSet = '0;               // offset 3: ack at slot 1
    chk(vecValid == 0, "R10 no early vector", vecValid, 0);
    @(negedge clk);                            // offset 4: slot 2
    chk(vecValid == 1 && vecData == 8'h12, "R10 far slot first", vecData, 8'h12);
    @(negedge clk);                            // offset 5
    chk(vecValid == 0, "R10 gap", vecValid, 0);
    @(negedge clk);                            // offset 6: slot 0
    chk(vecValid == 1 && vecData == 8'h10, "R10 late slot next", vecData, 8'h10);
    @(negedge clk);
    chk(intReq == 0, "R10 drained", intReq, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule